// File: doc/BRIEF.md
# Bit-clock ratio and sample-rate detector

This block sits beside the target-mode receiver of an audio serial port. The far end supplies the bit clock and the frame sync. From those two signals alone, the block works out how many bit-clock cycles make up one frame and which nominal sample rate the frame sync runs at. It reports the result as a pair of configuration codes and a rate-family bit, so that the clock dividers downstream can be set up without any host programming.

Two measurements run side by side. In the bit-clock domain, a counter counts bit-clock edges between rising frame-sync edges and matches the count exactly against the eleven supported ratios. In the reference-clock domain, the frame-sync period is measured in cycles of a fixed reference clock. That count is then matched within a ±2 % window against the fourteen nominal rates of the 48 kHz and 44.1 kHz families. The ratio result crosses into the reference domain through a four-phase request/acknowledge handshake, and each side of that handshake uses two synchronizing flops.

A result counts as settled only after three consecutive frames give the same value. A settled pair whose bit-clock frequency (ratio × sample rate) lies outside the supported band is reported as reserved instead of valid. When the port runs in controller mode, detection is suspended.

Top module: `brd_clock_ratio_detect`

## Requirements
- R1: The bit-clock edges counted between consecutive rising frame-sync edges are matched exactly to a ratio code on `ratio_code`. The codes are 0 to 10, standing for 16, 24, 32, 48, 64, 96, 128, 192, 256, 384 and 512 respectively.
- R2: The frame-sync period is counted in reference-clock cycles and compared with REF_HZ/fs, with a tolerance of ±TOL_PCT percent. For the 48 kHz family, `rate_family` is 0 and `rate_code` is 0 to 6, standing for 8, 16, 24, 32, 48, 96 and 192 kHz.
- R3: For the 44.1 kHz family, `rate_family` is 1 and `rate_code` is 0 to 6, standing for 7.35, 14.7, 22.05, 29.4, 44.1, 88.2 and 176.4 kHz.
- R4: A bit-clock count per frame that is not one of the eleven supported ratios keeps both `cfg_valid` and `rsv_err` at 0.
- R5: A frame-sync period that falls outside every rate window keeps both `cfg_valid` and `rsv_err` at 0.
- R6: A settled pair whose ratio × rate exceeds 24.576 MHz drives `rsv_err` to 1 and `cfg_valid` to 0. The two flags are never both 1.
- R7: In the 48 kHz family, a settled pair whose ratio × rate is below 0.256 MHz is reserved (`rsv_err`=1, `cfg_valid`=0). A pair at exactly 0.256 MHz is valid.
- R8: In the 44.1 kHz family, a settled pair whose ratio × rate is below 0.3528 MHz is reserved. A pair at exactly 0.3528 MHz is valid.
- R9: `cfg_valid` or `rsv_err` rises only after three consecutive frames have given the same ratio result and three consecutive frames have given the same rate result.
- R10: A frame whose measured result differs from the one before it drops `cfg_valid` before the following frame ends.
- R11: While `ctl_mode` is 1, `cfg_valid` and `rsv_err` are 0 from the next reference cycle onward. After `ctl_mode` returns to 0, three new stable rate frames are needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fixed reference clock, nominally REF_HZ |
| rst | input | 1 | Synchronous active-high reset (reference domain, bridged into the bit-clock domain) |
| ctl_mode | input | 1 | 1 = port is in controller mode, detection suspended |
| bclk | input | 1 | Incoming serial bit clock |
| fsync | input | 1 | Incoming frame sync, launched on the bit clock |
| ratio_code | output | 4 | Detected bit-clock-per-frame code |
| rate_code | output | 3 | Detected sample-rate code within the family |
| rate_family | output | 1 | 0 = 48 kHz family, 1 = 44.1 kHz family |
| cfg_valid | output | 1 | Settled, supported ratio and rate pair |
| rsv_err | output | 1 | Settled pair lies in a reserved cell |

## Verification
Some properties are checked on every cycle. The assertions check that a settled flag falls in the cycle after a frame that disagrees with the previous one. They also check that the flag only rises right after a frame measurement, and that the crossing word stays frozen while its request is up. In addition, they check that controller mode silences both flags on the next reference edge and that a valid output always carries in-range codes. Other behaviours are shown only by the bench's scenarios: the actual code mapping for each ratio and rate, the band edges of the reserved cells in both families, rejection of an unsupported count or an off-window period, and the three-frame delay after a change.

// File: rtl/brd_pkg.sv
package brd_pkg;

  localparam int RATIO_N = 11;
  localparam int RATE_N  = 7;
  localparam int RATIO_W = 4;
  localparam int RATE_W  = 3;

  localparam int unsigned BCLK_MAX_HZ   = 32'd24576000;
  localparam int unsigned BCLK_MIN48_HZ = 32'd256000;
  localparam int unsigned BCLK_MIN44_HZ = 32'd352800;

  // even codes: 16 * 2^(k/2), odd codes: 24 * 2^(k/2)
  function automatic int unsigned ratio_value(input logic [RATIO_W-1:0] k);
    int unsigned base;
    base = k[0] ? 32'd24 : 32'd16;
    return base << k[RATIO_W-1:1];
  endfunction

  // rate multipliers 1,2,3,4,6,12,24 over the family base
  function automatic int unsigned rate_mult(input logic [RATE_W-1:0] r);
    if (r < 3'd4) return 32'(r) + 32'd1;
    else          return 32'd6 << (r - 3'd4);
  endfunction

  function automatic int unsigned fs_hz(input logic fam, input logic [RATE_W-1:0] r);
    return (fam ? 32'd7350 : 32'd8000) * rate_mult(r);
  endfunction

  function automatic logic is_reserved(input logic [RATIO_W-1:0] k,
                                       input logic fam,
                                       input logic [RATE_W-1:0] r);
    int unsigned bck;
    bck = ratio_value(k) * fs_hz(fam, r);
    return (bck > BCLK_MAX_HZ) || (bck < (fam ? BCLK_MIN44_HZ : BCLK_MIN48_HZ));
  endfunction

endpackage

// File: rtl/brd_stab.sv
module brd_stab #(
  parameter int W      = 5,
  parameter int FRAMES = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         evt,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic         stable
);
  localparam int AGW = $clog2(FRAMES + 1);

  logic [AGW-1:0] agree;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cur    <= '0;
      agree  <= '0;
      stable <= 1'b0;
    end else if (evt) begin
      cur <= din;
      if (din == cur) begin
        if (agree != AGW'(FRAMES - 1)) agree <= agree + 1'b1;
        stable <= (agree >= AGW'(FRAMES - 2));
      end else begin
        agree  <= '0;
        stable <= 1'b0;
      end
    end
  end

  AST_STAB_DROP: assert property (@(posedge clk) disable iff (rst)
    (evt && (din != cur)) |=> !stable);  // R10

  AST_STAB_RISE_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(stable) |-> $past(evt));  // R9

endmodule

// File: rtl/brd_ratio_meter.sv
module brd_ratio_meter
  import brd_pkg::*;
#(
  parameter int CNT_W         = 10,
  parameter int STABLE_FRAMES = 3
) (
  input  logic               bclk,
  input  logic               rst,
  input  logic               fsync,
  output logic               stable,
  output logic               ok,
  output logic [RATIO_W-1:0] code
);
  logic             fs_q;
  logic             primed;
  logic             evt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] meas;
  logic             rise;

  assign rise = fsync & ~fs_q;

  // meas = number of bclk rising edges from one frame start to the next
  always_ff @(posedge bclk) begin
    if (rst) begin
      fs_q   <= 1'b0;
      primed <= 1'b0;
      evt    <= 1'b0;
      cnt    <= '0;
      meas   <= '0;
    end else begin
      fs_q <= fsync;
      evt  <= rise & primed;
      if (rise) begin
        primed <= 1'b1;
        meas   <= cnt + 1'b1;
        cnt    <= '0;
      end else if (cnt != '1) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  logic [RATIO_N-1:0] hit;
  for (genvar k = 0; k < RATIO_N; k++) begin : g_ratio
    assign hit[k] = (meas == CNT_W'(ratio_value(RATIO_W'(k))));
  end

  logic               m_ok;
  logic [RATIO_W-1:0] m_code;
  always_comb begin
    m_ok   = 1'b0;
    m_code = '0;
    for (int k = 0; k < RATIO_N; k++) begin
      if (hit[k] && !m_ok) begin
        m_ok   = 1'b1;
        m_code = RATIO_W'(k);
      end
    end
  end

  logic [RATIO_W:0] cur;
  brd_stab #(.W(RATIO_W + 1), .FRAMES(STABLE_FRAMES)) i_stab (
    .clk    (bclk),
    .rst    (rst),
    .clr    (1'b0),
    .evt    (evt),
    .din    ({m_ok, m_code}),
    .cur    (cur),
    .stable (stable)
  );
  assign ok   = cur[RATIO_W];
  assign code = cur[RATIO_W-1:0];

  AST_RATIO_ONE_HIT: assert property (@(posedge bclk) disable iff (rst)
    $onehot0(hit));  // R1

endmodule

// File: rtl/brd_rate_meter.sv
module brd_rate_meter
  import brd_pkg::*;
#(
  parameter int REF_HZ        = 24576000,
  parameter int TOL_PCT       = 2,
  parameter int CNT_W         = 13,
  parameter int STABLE_FRAMES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              fsync,
  output logic              stable,
  output logic              ok,
  output logic              fam,
  output logic [RATE_W-1:0] code
);
  localparam int WIN_N = 2 * RATE_N;

  logic             fs_m, fs_s, fs_q;
  logic             primed;
  logic             evt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] meas;
  logic             rise;

  assign rise = fs_s & ~fs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_m   <= 1'b0;
      fs_s   <= 1'b0;
      fs_q   <= 1'b0;
      primed <= 1'b0;
      evt    <= 1'b0;
      cnt    <= '0;
      meas   <= '0;
    end else begin
      fs_m <= fsync;
      fs_s <= fs_m;
      fs_q <= fs_s;
      evt  <= rise & primed;
      if (rise) begin
        primed <= 1'b1;
        meas   <= cnt + 1'b1;
        cnt    <= '0;
      end else if (cnt != '1) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // window i: family i/RATE_N, rate code i%RATE_N
  logic [WIN_N-1:0] hit;
  for (genvar i = 0; i < WIN_N; i++) begin : g_win
    localparam longint FS   = longint'(fs_hz(1'(i / RATE_N), RATE_W'(i % RATE_N)));
    localparam longint LO_L = (longint'(REF_HZ) * longint'(100 - TOL_PCT)) / (100 * FS);
    localparam longint HI_L = (longint'(REF_HZ) * longint'(100 + TOL_PCT)) / (100 * FS);
    localparam logic [CNT_W-1:0] LO = CNT_W'(LO_L);
    localparam logic [CNT_W-1:0] HI = CNT_W'(HI_L);
    assign hit[i] = (meas >= LO) && (meas <= HI);
  end

  logic              m_ok;
  logic              m_fam;
  logic [RATE_W-1:0] m_code;
  always_comb begin
    m_ok   = 1'b0;
    m_fam  = 1'b0;
    m_code = '0;
    for (int i = 0; i < WIN_N; i++) begin
      if (hit[i] && !m_ok) begin
        m_ok   = 1'b1;
        m_fam  = 1'(i / RATE_N);
        m_code = RATE_W'(i % RATE_N);
      end
    end
  end

  logic [RATE_W+1:0] cur;
  brd_stab #(.W(RATE_W + 2), .FRAMES(STABLE_FRAMES)) i_stab (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .evt    (evt),
    .din    ({m_ok, m_fam, m_code}),
    .cur    (cur),
    .stable (stable)
  );
  assign ok   = cur[RATE_W+1];
  assign fam  = cur[RATE_W];
  assign code = cur[RATE_W-1:0];

  AST_RATE_ONE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));  // R2

endmodule

// File: rtl/brd_hs_sync.sv
module brd_hs_sync #(
  parameter int W = 5
) (
  input  logic         clk_s,
  input  logic         rst_s,
  input  logic [W-1:0] din,
  input  logic         clk_d,
  input  logic         rst_d,
  output logic [W-1:0] dout
);
  logic         req, ack;
  logic         ack_m, ack_s;
  logic         req_m, req_s;
  logic [W-1:0] hold;

  always_ff @(posedge clk_s) begin
    if (rst_s) begin
      req   <= 1'b0;
      ack_m <= 1'b0;
      ack_s <= 1'b0;
      hold  <= '0;
    end else begin
      ack_m <= ack;
      ack_s <= ack_m;
      if (!req && !ack_s) begin
        hold <= din;
        req  <= 1'b1;
      end else if (req && ack_s) begin
        req <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_d) begin
    if (rst_d) begin
      req_m <= 1'b0;
      req_s <= 1'b0;
      ack   <= 1'b0;
      dout  <= '0;
    end else begin
      req_m <= req;
      req_s <= req_m;
      if (req_s && !ack) begin
        dout <= hold;
        ack  <= 1'b1;
      end else if (!req_s && ack) begin
        ack <= 1'b0;
      end
    end
  end

  AST_HS_HOLD_FROZEN: assert property (@(posedge clk_s) disable iff (rst_s)
    (req && $past(req)) |-> $stable(hold));  // R1

  AST_HS_ACK_AFTER_REQ: assert property (@(posedge clk_d) disable iff (rst_d)
    $rose(ack) |-> $past(req_s));  // R1

endmodule

// File: rtl/brd_clock_ratio_detect.sv
module brd_clock_ratio_detect
  import brd_pkg::*;
#(
  parameter int REF_HZ        = 24576000,
  parameter int TOL_PCT       = 2,
  parameter int BCLK_CNT_W    = 10,
  parameter int REF_CNT_W     = 13,
  parameter int STABLE_FRAMES = 3
) (
  input  logic               clk_ref,
  input  logic               rst,
  input  logic               ctl_mode,
  input  logic               bclk,
  input  logic               fsync,
  output logic [RATIO_W-1:0] ratio_code,
  output logic [RATE_W-1:0]  rate_code,
  output logic               rate_family,
  output logic               cfg_valid,
  output logic               rsv_err
);
  localparam int XW = RATIO_W + 2;

  // reset bridge into the bit-clock domain
  logic rst_b1, rst_b;
  always_ff @(posedge bclk) begin
    rst_b1 <= rst;
    rst_b  <= rst_b1;
  end

  logic               b_stable, b_ok;
  logic [RATIO_W-1:0] b_code;
  brd_ratio_meter #(.CNT_W(BCLK_CNT_W), .STABLE_FRAMES(STABLE_FRAMES)) i_ratio (
    .bclk   (bclk),
    .rst    (rst_b),
    .fsync  (fsync),
    .stable (b_stable),
    .ok     (b_ok),
    .code   (b_code)
  );

  logic [XW-1:0] x_word;
  brd_hs_sync #(.W(XW)) i_xing (
    .clk_s (bclk),
    .rst_s (rst_b),
    .din   ({b_stable, b_ok, b_code}),
    .clk_d (clk_ref),
    .rst_d (rst),
    .dout  (x_word)
  );

  logic               x_stable, x_ok;
  logic [RATIO_W-1:0] x_code;
  assign x_stable = x_word[XW-1];
  assign x_ok     = x_word[XW-2];
  assign x_code   = x_word[RATIO_W-1:0];

  logic              q_stable, q_ok, q_fam;
  logic [RATE_W-1:0] q_code;
  brd_rate_meter #(
    .REF_HZ(REF_HZ), .TOL_PCT(TOL_PCT),
    .CNT_W(REF_CNT_W), .STABLE_FRAMES(STABLE_FRAMES)
  ) i_rate (
    .clk    (clk_ref),
    .rst    (rst),
    .clr    (ctl_mode),
    .fsync  (fsync),
    .stable (q_stable),
    .ok     (q_ok),
    .fam    (q_fam),
    .code   (q_code)
  );

  logic settled, rsv_cell;
  assign settled  = x_stable & x_ok & q_stable & q_ok;
  assign rsv_cell = is_reserved(x_code, q_fam, q_code);

  always_ff @(posedge clk_ref) begin
    if (rst || ctl_mode) begin
      ratio_code  <= '0;
      rate_code   <= '0;
      rate_family <= 1'b0;
      cfg_valid   <= 1'b0;
      rsv_err     <= 1'b0;
    end else begin
      ratio_code  <= x_code;
      rate_code   <= q_code;
      rate_family <= q_fam;
      cfg_valid   <= settled & ~rsv_cell;
      rsv_err     <= settled & rsv_cell;
    end
  end

  AST_CTL_QUIET: assert property (@(posedge clk_ref) disable iff (rst)
    ctl_mode |=> (!cfg_valid && !rsv_err));  // R11

  AST_VALID_CODES_IN_RANGE: assert property (@(posedge clk_ref) disable iff (rst)
    cfg_valid |-> ((ratio_code < RATIO_W'(RATIO_N)) && (rate_code < RATE_W'(RATE_N))));  // R1

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_ref) disable iff (rst)
    !(cfg_valid && rsv_err));  // R6

endmodule

// File: tb/test_brd_clock_ratio_detect.sv
`timescale 1ns/1ps
module test_brd_clock_ratio_detect;

  // clk stands in for the 24.576 MHz reference: one 8 ns period = one
  // reference cycle, so a frame of fs lasts (24576000/fs) * 8 ns here.
  localparam real REF_HZ_R = 24576000.0;
  localparam real T_REF    = 8.0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_mode = 1'b0;
  logic       bclk = 1'b0;
  logic       fsync = 1'b0;
  logic [3:0] ratio_code;
  logic [2:0] rate_code;
  logic       rate_family;
  logic       cfg_valid;
  logic       rsv_err;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;

  int  g_ratio = 64;
  real g_half  = 32.0;

  always #4 clk = ~clk;

  brd_clock_ratio_detect i_brd_clock_ratio_detect (
    .clk_ref     (clk),
    .rst         (rst),
    .ctl_mode    (ctl_mode),
    .bclk        (bclk),
    .fsync       (fsync),
    .ratio_code  (ratio_code),
    .rate_code   (rate_code),
    .rate_family (rate_family),
    .cfg_valid   (cfg_valid),
    .rsv_err     (rsv_err)
  );

  // frame generator: fsync high for the first half of each frame,
  // changed while bclk is low; settings are taken at each frame start
  initial begin
    forever begin : frame
      int  n;
      real h;
      n = g_ratio;
      h = g_half;
      for (int i = 0; i < n; i++) begin
        fsync = (i < n / 2);
        #(h) bclk = 1'b1;
        #(h) bclk = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int ratio, input real fs);
    g_ratio = ratio;
    g_half  = (REF_HZ_R / fs) * T_REF / (2.0 * ratio);
  endtask

  task automatic settle(input int frames);
    repeat (frames) @(posedge fsync);
    #600;
    @(negedge clk);
  endtask

  task automatic expect_cfg(input string req, input int v, input int e,
                            input int rc, input int sc, input int fm);
    chk(req, "cfg_valid", cfg_valid, v);
    chk(req, "rsv_err", rsv_err, e);
    if (v || e) begin
      chk(req, "ratio_code", ratio_code, rc);
      chk(req, "rate_code", rate_code, sc);
      chk(req, "rate_family", rate_family, fm);
    end
  endtask

  task automatic t_reset();
    repeat (20) @(negedge clk);
    chk("R9", "reset cfg_valid", cfg_valid, 0);
    chk("R9", "reset rsv_err", rsv_err, 0);
    chk("R9", "reset ratio_code", ratio_code, 0);
  endtask

  task automatic t_base48();
    set_cfg(64, 48000.0);  settle(8);
    expect_cfg("R1", 1, 0, 4, 4, 0);
    set_cfg(32, 192000.0); settle(8);
    expect_cfg("R2", 1, 0, 2, 6, 0);
    set_cfg(512, 48000.0); settle(8);
    expect_cfg("R1", 1, 0, 10, 4, 0);
  endtask

  task automatic t_family441();
    set_cfg(256, 44100.0); settle(8);
    expect_cfg("R3", 1, 0, 8, 4, 1);
    set_cfg(128, 176400.0); settle(8);
    expect_cfg("R3", 1, 0, 6, 6, 1);
  endtask

  task automatic t_high_rsv();
    set_cfg(256, 192000.0); settle(8);
    expect_cfg("R6", 0, 1, 8, 6, 0);
    set_cfg(384, 96000.0);  settle(8);
    expect_cfg("R6", 0, 1, 9, 5, 0);
  endtask

  task automatic t_low48();
    set_cfg(24, 8000.0); settle(7);
    expect_cfg("R7", 0, 1, 1, 0, 0);
    set_cfg(32, 8000.0); settle(7);
    expect_cfg("R7", 1, 0, 2, 0, 0);
  endtask

  task automatic t_low441();
    set_cfg(16, 14700.0); settle(7);
    expect_cfg("R8", 0, 1, 0, 1, 1);
    set_cfg(24, 14700.0); settle(7);
    expect_cfg("R8", 1, 0, 1, 1, 1);
  endtask

  task automatic t_unsupported();
    set_cfg(20, 48000.0); settle(8);
    expect_cfg("R4", 0, 0, 0, 0, 0);
  endtask

  task automatic t_off_rate();
    set_cfg(64, 40000.0); settle(8);
    expect_cfg("R5", 0, 0, 0, 0, 0);
  endtask

  task automatic t_change();
    set_cfg(64, 48000.0); settle(8);
    expect_cfg("R10", 1, 0, 4, 4, 0);
    set_cfg(128, 48000.0);
    @(posedge fsync);          // first frame with new ratio starts
    settle(1);                 // it has ended and differs
    chk("R10", "valid after change", cfg_valid, 0);
    settle(1);                 // only two equal frames so far
    chk("R9", "valid after two frames", cfg_valid, 0);
    settle(4);
    expect_cfg("R9", 1, 0, 6, 4, 0);
  endtask

  task automatic t_ctl();
    set_cfg(96, 48000.0); settle(8);
    expect_cfg("R11", 1, 0, 5, 4, 0);
    ctl_mode = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "ctl cfg_valid", cfg_valid, 0);
    chk("R11", "ctl rsv_err", rsv_err, 0);
    settle(2);
    chk("R11", "ctl held cfg_valid", cfg_valid, 0);
    ctl_mode = 1'b0;
    settle(1);
    chk("R11", "restart cfg_valid", cfg_valid, 0);
    settle(5);
    expect_cfg("R11", 1, 0, 5, 4, 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    set_cfg(64, 48000.0);
    t_reset();
    rst = 1'b0;
    t_base48();
    t_family441();
    t_high_rsv();
    t_unsupported();
    t_off_rate();
    t_change();
    t_ctl();
    t_low441();
    t_low48();
    summary();
  end

endmodule